// File: doc/BRIEF.md
# I2C Bus Timing Generator

This block turns bit-level requests from an I2C master sequencer into the SCL waveform and the SDA conditions on the bus. The sequencer asks for one of five operations: open a transaction with a START, issue a repeated START, close with a STOP, send one data bit, or receive one data bit. The block times every phase of the operation by counting pulses of a reference tick input, which comes from a divider off an internal 16 MHz clock. It returns a one-cycle done strobe when the operation ends and, for a receive, the sampled SDA value.

Every timing quantity has its own count input: SCL high period, SCL low period, START hold, repeated-START setup and STOP setup. Typical hold and setup counts are 0x0a ticks for fast mode, and 0x47 (START hold) or 0x50 (repeated-START setup) for standard mode. If a clock count is zero, the SCL clock stops where it is until a nonzero count is supplied.

Both bus lines are open-drain. They are modelled as drive-low enables, and the block never drives a line high. Clock stretching, glitch filtering and arbitration are handled elsewhere.

Top module: `i2c_timing_gen`

## Requirements
- R1: After reset both drive-low enables are 0 (lines released), busy_o is 0, done_o is 0 and rx_bit_o is 1.
- R2: START (op code 0): SDA is pulled low while SCL stays released for exactly cfg_start_hold_i ticks. Then SCL is pulled low and the operation completes with both lines low.
- R3: Send bit (op code 3): SCL is low for cfg_scl_low_i ticks with SDA pulled low when req_bit_i is 0 and released when it is 1. SCL is then released for cfg_scl_high_i ticks, and SCL is low again at completion. SDA never changes while SCL is released during a data bit.
- R4: Receive bit (op code 4): SDA is released through both phases. sda_in_i is sampled on the high-phase tick whose zero-based index is floor(cfg_scl_high_i/2), and that value is on rx_bit_o from the done cycle on.
- R5: Repeated START (op code 1): SDA is released while SCL is low for cfg_scl_low_i ticks. SCL is then released for cfg_rstart_setup_i ticks, then SDA is pulled low with SCL released for cfg_start_hold_i ticks, and SCL is pulled low at completion.
- R6: STOP (op code 2): SDA is held low with SCL low for cfg_scl_low_i ticks, then SCL is released for cfg_stop_setup_i ticks. Then SDA is released, and both lines stay released afterwards.
- R7: While cfg_scl_high_i or cfg_scl_low_i is zero, a phase timed by a clock count does not advance: SCL holds its level and no done occurs. Counting resumes from the start of that phase once both counts are nonzero.
- R8: A START-hold, repeated-START-setup or STOP-setup count of zero lasts one tick.
- R9: A request (req_valid_i high, op code 0 to 4) is taken only in a cycle where busy_o is 0. Requests presented while busy_o is 1 are ignored and do not change the operation in progress.
- R10: done_o is high for exactly one cycle per operation, in the same cycle that busy_o returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Reference tick enable, one cycle wide |
| cfg_scl_high_i | input | CW (7) | SCL high period in ticks; zero stops SCL |
| cfg_scl_low_i | input | CW (7) | SCL low period in ticks; zero stops SCL |
| cfg_start_hold_i | input | SW (8) | START hold time in ticks |
| cfg_rstart_setup_i | input | SW (8) | Repeated-START setup time in ticks |
| cfg_stop_setup_i | input | SW (8) | STOP setup time in ticks |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Operation: 0 START, 1 repeated START, 2 STOP, 3 send bit, 4 receive bit |
| req_bit_i | input | 1 | Bit value for a send |
| sda_in_i | input | 1 | Sensed SDA line level |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rx_bit_o | output | 1 | Last received bit |
| scl_drive_low_o | output | 1 | Pull SCL low when 1 |
| sda_drive_low_o | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that the sequencer issues a START only when the bus is idle, and issues any other operation only inside an open transaction. They also assume that the timing counts stay constant while a phase is counting. The one exception is raising a zero clock count back to a nonzero value while SCL is halted. The stimulus keeps to these rules: operations always follow START, then data bits or a repeated START, then STOP; configuration changes only between operations or during a halt; and the stray request used to test R9 is presented only while busy_o is high.

// File: rtl/i2c_tgen_pkg.sv
// Shared types for the I2C bus timing generator.
// Assumes op codes 5..7 are never meant to be accepted.
package i2c_tgen_pkg;

    // Bit-level operations a sequencer may request.
    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_STOP   = 3'd2,
        OP_WRITE  = 3'd3,
        OP_READ   = 3'd4
    } bus_op_e;

    // Bus phases; each busy phase is timed by one count.
    typedef enum logic [3:0] {
        PH_IDLE,      // bus free, both lines released
        PH_PARK,      // transaction open, SCL held low, waiting
        PH_S_HOLD,    // START: SDA low, SCL high
        PH_R_LOW,     // repeated START: SDA released, SCL low
        PH_R_SETUP,   // repeated START: both released
        PH_R_HOLD,    // repeated START: SDA low, SCL high
        PH_P_LOW,     // STOP: SDA low, SCL low
        PH_P_SETUP,   // STOP: SDA low, SCL high
        PH_B_LOW,     // data bit: SCL low, SDA set
        PH_B_HIGH     // data bit: SCL high, SDA stable
    } phase_e;

endpackage

// File: rtl/i2c_tgen_sel.sv
// Selects the tick count that times the current phase and decides
// whether the phase timer may run. Clock-count phases stop when
// either SCL count is zero. Purely combinational.
module i2c_tgen_sel
    import i2c_tgen_pkg::*;
#(
    parameter int CW = 7,
    parameter int SW = 8,
    parameter int LW = 8
) (
    input  phase_e          phase_i,
    input  logic [CW-1:0]   scl_high_i,
    input  logic [CW-1:0]   scl_low_i,
    input  logic [SW-1:0]   start_hold_i,
    input  logic [SW-1:0]   rstart_setup_i,
    input  logic [SW-1:0]   stop_setup_i,
    output logic [LW-1:0]   limit_o,
    output logic            run_o
);

    logic clk_ok;

    // SCL toggles only while both clock counts are nonzero.
    assign clk_ok = (scl_high_i != '0) && (scl_low_i != '0);

    // Map phase to its count and run permission.
    always_comb begin
        limit_o = '0;
        run_o   = 1'b0;
        case (phase_i)
            PH_S_HOLD, PH_R_HOLD: begin
                limit_o = LW'(start_hold_i);
                run_o   = 1'b1;
            end
            PH_R_SETUP: begin
                limit_o = LW'(rstart_setup_i);
                run_o   = 1'b1;
            end
            PH_P_SETUP: begin
                limit_o = LW'(stop_setup_i);
                run_o   = 1'b1;
            end
            PH_R_LOW, PH_P_LOW, PH_B_LOW: begin
                limit_o = LW'(scl_low_i);
                run_o   = clk_ok;
            end
            PH_B_HIGH: begin
                limit_o = LW'(scl_high_i);
                run_o   = clk_ok;
            end
            default: begin
                limit_o = '0;
                run_o   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/i2c_tgen_timer.sv
// Phase timer: counts reference ticks elapsed in the current phase.
// A limit of zero is treated as one tick. Flags the final tick and
// the tick at index floor(limit/2). Assumes the limit is steady
// while running.
module i2c_tgen_timer #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic [LW-1:0] limit_i,
    output logic          expire_o,
    output logic          mid_o
);

    logic [LW-1:0] cnt_q;
    logic [LW-1:0] lim_eff;

    // Zero-length phases still last one tick.
    assign lim_eff  = (limit_i == '0) ? LW'(1) : limit_i;
    assign expire_o = tick_i && run_i && (cnt_q >= (lim_eff - LW'(1)));
    assign mid_o    = tick_i && run_i && (cnt_q == (lim_eff >> 1));

    // Elapsed-tick counter, cleared at every phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && run_i) begin
            cnt_q <= cnt_q + LW'(1);
        end
    end

    // A running phase never counts past its own length.
    assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < lim_eff));

    // A zero-length phase ends on its first tick.
    assert_zero_len_one_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && (limit_i == '0)) |-> expire_o);

endmodule

// File: rtl/i2c_tgen_seq.sv
// Bus sequencer: accepts one bit-level request while not busy, walks
// the phases of that operation and drives the open-drain enables.
// All bus enables are registered and change on phase boundaries only.
// Assumes START is requested only from idle, others only while parked.
module i2c_tgen_seq
    import i2c_tgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid_i,
    input  logic [2:0] req_op_i,
    input  logic       req_bit_i,
    input  logic       sda_in_i,
    input  logic       expire_i,
    input  logic       mid_i,
    input  logic       run_i,
    output phase_e     phase_o,
    output logic       accept_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       rx_bit_o,
    output logic       scl_low_o,
    output logic       sda_low_o
);

    phase_e  ph_q;
    bus_op_e op_q;
    logic    scl_low_q;
    logic    sda_low_q;
    logic    done_q;
    logic    rx_q;
    logic    open_slot;

    // Requests land only in the two waiting phases.
    assign open_slot = (ph_q == PH_IDLE) || (ph_q == PH_PARK);
    assign accept_o  = req_valid_i && open_slot && (req_op_i <= 3'd4);
    assign busy_o    = !open_slot;
    assign phase_o   = ph_q;
    assign done_o    = done_q;
    assign rx_bit_o  = rx_q;
    assign scl_low_o = scl_low_q;
    assign sda_low_o = sda_low_q;

    // Phase walk and line drive for every operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            op_q      <= OP_START;
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
            done_q    <= 1'b0;
            rx_q      <= 1'b1;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                PH_IDLE, PH_PARK: begin
                    if (accept_o) begin
                        op_q <= bus_op_e'(req_op_i);
                        case (bus_op_e'(req_op_i))
                            OP_START: begin
                                ph_q      <= PH_S_HOLD;
                                sda_low_q <= 1'b1;
                            end
                            OP_RSTART: begin
                                ph_q      <= PH_R_LOW;
                                sda_low_q <= 1'b0;
                            end
                            OP_STOP: begin
                                ph_q      <= PH_P_LOW;
                                sda_low_q <= 1'b1;
                            end
                            OP_WRITE: begin
                                ph_q      <= PH_B_LOW;
                                sda_low_q <= !req_bit_i;
                            end
                            OP_READ: begin
                                ph_q      <= PH_B_LOW;
                                sda_low_q <= 1'b0;
                            end
                            default: ph_q <= ph_q;
                        endcase
                    end
                end
                PH_S_HOLD, PH_R_HOLD: begin
                    if (expire_i) begin
                        scl_low_q <= 1'b1;
                        ph_q      <= PH_PARK;
                        done_q    <= 1'b1;
                    end
                end
                PH_R_LOW: begin
                    if (expire_i) begin
                        scl_low_q <= 1'b0;
                        ph_q      <= PH_R_SETUP;
                    end
                end
                PH_R_SETUP: begin
                    if (expire_i) begin
                        sda_low_q <= 1'b1;
                        ph_q      <= PH_R_HOLD;
                    end
                end
                PH_P_LOW: begin
                    if (expire_i) begin
                        scl_low_q <= 1'b0;
                        ph_q      <= PH_P_SETUP;
                    end
                end
                PH_P_SETUP: begin
                    if (expire_i) begin
                        sda_low_q <= 1'b0;
                        ph_q      <= PH_IDLE;
                        done_q    <= 1'b1;
                    end
                end
                PH_B_LOW: begin
                    if (expire_i) begin
                        scl_low_q <= 1'b0;
                        ph_q      <= PH_B_HIGH;
                    end
                end
                PH_B_HIGH: begin
                    if (mid_i && (op_q == OP_READ)) begin
                        rx_q <= sda_in_i;
                    end
                    if (expire_i) begin
                        scl_low_q <= 1'b1;
                        ph_q      <= PH_PARK;
                        done_q    <= 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // SDA moves under a released SCL only for bus conditions.
    assert_sda_still_in_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low_q && !$past(scl_low_q) && !$stable(sda_low_q))
            |-> (op_q == OP_START || op_q == OP_RSTART || op_q == OP_STOP));

    // Completion strobe never lasts beyond one cycle.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // A halted clock phase leaves SCL where it is.
    assert_halt_holds_scl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !run_i) |=> $stable(scl_low_q));

    // Input rule: START only on a free bus.
    assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ph_q == PH_IDLE) |-> (req_op_i == 3'd0));

    // Input rule: no second START inside an open transaction.
    assert_no_start_in_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ph_q == PH_PARK) |-> (req_op_i != 3'd0));

    // After a STOP completes the bus is fully released.
    assert_stop_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && ph_q == PH_IDLE) |-> (!scl_low_q && !sda_low_q));

endmodule

// File: rtl/i2c_timing_gen.sv
// I2C bus timing generator top: joins count selection, the phase
// timer and the sequencer. Open-drain lines appear as drive-low
// enables. Assumes tick_i is a single-cycle enable.
module i2c_timing_gen
    import i2c_tgen_pkg::*;
#(
    parameter int CW = 7,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [CW-1:0] cfg_scl_high_i,
    input  logic [CW-1:0] cfg_scl_low_i,
    input  logic [SW-1:0] cfg_start_hold_i,
    input  logic [SW-1:0] cfg_rstart_setup_i,
    input  logic [SW-1:0] cfg_stop_setup_i,
    input  logic          req_valid_i,
    input  logic [2:0]    req_op_i,
    input  logic          req_bit_i,
    input  logic          sda_in_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          rx_bit_o,
    output logic          scl_drive_low_o,
    output logic          sda_drive_low_o
);

    localparam int LW = (CW > SW) ? CW : SW;

    phase_e        phase;
    logic [LW-1:0] limit;
    logic          run;
    logic          expire;
    logic          mid;
    logic          accept;
    logic          clear;

    // Timer restarts on every accepted request and phase end.
    assign clear = accept || expire;

    i2c_tgen_sel #(.CW(CW), .SW(SW), .LW(LW)) u_sel (
        .phase_i        (phase),
        .scl_high_i     (cfg_scl_high_i),
        .scl_low_i      (cfg_scl_low_i),
        .start_hold_i   (cfg_start_hold_i),
        .rstart_setup_i (cfg_rstart_setup_i),
        .stop_setup_i   (cfg_stop_setup_i),
        .limit_o        (limit),
        .run_o          (run)
    );

    i2c_tgen_timer #(.LW(LW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .tick_i   (tick_i),
        .run_i    (run),
        .limit_i  (limit),
        .expire_o (expire),
        .mid_o    (mid)
    );

    i2c_tgen_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_op_i    (req_op_i),
        .req_bit_i   (req_bit_i),
        .sda_in_i    (sda_in_i),
        .expire_i    (expire),
        .mid_i       (mid),
        .run_i       (run),
        .phase_o     (phase),
        .accept_o    (accept),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rx_bit_o    (rx_bit_o),
        .scl_low_o   (scl_drive_low_o),
        .sda_low_o   (sda_drive_low_o)
    );

endmodule

// File: tb/i2c_timing_gen_tb.sv
// Directed bench: one task per scenario. A negedge monitor drives the
// reference tick and tallies busy ticks per line signature
// {scl_low, sda_low}: 0 both released, 1 SDA low only, 2 SCL low only,
// 3 both low.
module i2c_timing_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;
    localparam int CW = 7;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] scl_high = '0;
    logic [CW-1:0] scl_low = '0;
    logic [SW-1:0] start_hold = '0;
    logic [SW-1:0] rstart_setup = '0;
    logic [SW-1:0] stop_setup = '0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic          req_bit = 1'b0;
    logic          sda_in = 1'b1;
    logic          busy, done, rx_bit, scl_dl, sda_dl;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int tally [4];
    int snap [4];
    int d [4];
    int div_cnt = 0;
    bit mid_mode = 0;
    bit mid_val = 0;
    int mid_idx = 0;
    int hi_base = 0;
    bit tk;
    int sig;
    bit got_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_timing_gen #(.CW(CW), .SW(SW)) dut_i (
        .clk                (clk),
        .rst_n              (rst_n),
        .tick_i             (tick),
        .cfg_scl_high_i     (scl_high),
        .cfg_scl_low_i      (scl_low),
        .cfg_start_hold_i   (start_hold),
        .cfg_rstart_setup_i (rstart_setup),
        .cfg_stop_setup_i   (stop_setup),
        .req_valid_i        (req_valid),
        .req_op_i           (req_op),
        .req_bit_i          (req_bit),
        .sda_in_i           (sda_in),
        .busy_o             (busy),
        .done_o             (done),
        .rx_bit_o           (rx_bit),
        .scl_drive_low_o    (scl_dl),
        .sda_drive_low_o    (sda_dl)
    );

    // Tick generation, SDA stimulus and busy-tick tally.
    initial begin
        for (int i = 0; i < 4; i++) tally[i] = 0;
    end

    always @(negedge clk) begin
        tk = (div_cnt == TICK_DIV - 1);
        div_cnt = tk ? 0 : div_cnt + 1;
        tick = tk;
        sig = {30'd0, scl_dl, sda_dl};
        if (mid_mode)
            sda_in = (tk && busy && sig == 0 && (tally[0] - hi_base) == mid_idx) ? mid_val : !mid_val;
        else
            sda_in = 1'b1;
        if (tk && busy) tally[sig] = tally[sig] + 1;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int hi, input int lo, input int sh, input int rs, input int ps);
        scl_high = CW'(hi);
        scl_low = CW'(lo);
        start_hold = SW'(sh);
        rstart_setup = SW'(rs);
        stop_setup = SW'(ps);
    endtask

    // Issue one request, optionally a stray one while busy, wait for done.
    task automatic run_op(input int op, input bit b, input bit stray);
        for (int i = 0; i < 4; i++) snap[i] = tally[i];
        hi_base = tally[0];
        req_valid = 1'b1;
        req_op = 3'(op);
        req_bit = b;
        step();
        req_valid = 1'b0;
        if (stray) begin
            req_valid = 1'b1;
            req_op = 3'd2;
            step();
            req_valid = 1'b0;
        end
        got_done = 0;
        for (int n = 0; n < 5000 && !got_done; n++) begin
            if (done) got_done = 1;
            else step();
        end
        chk("R10 done seen", int'(got_done), 1);
        chk("R10 busy low with done", int'(busy), 0);
        for (int i = 0; i < 4; i++) d[i] = tally[i] - snap[i];
    endtask

    task automatic t_reset();
        chk("R1 scl released", int'(scl_dl), 0);
        chk("R1 sda released", int'(sda_dl), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 rx_bit", int'(rx_bit), 1);
    endtask

    task automatic t_start(input int sh);
        int exp_h;
        exp_h = (sh == 0) ? 1 : sh;
        run_op(0, 1'b0, 1'b0);
        chk("R2 start hold ticks", d[1], exp_h);
        chk("R2 no other phase", d[0] + d[2] + d[3], 0);
        chk("R2 scl low after", int'(scl_dl), 1);
        chk("R2 sda low after", int'(sda_dl), 1);
        if (sh == 0) chk("R8 zero hold one tick", d[1], 1);
    endtask

    task automatic t_write(input bit b, input int hi, input int lo);
        run_op(3, b, 1'b0);
        chk("R3 low phase ticks", b ? d[2] : d[3], lo);
        chk("R3 high phase ticks", b ? d[0] : d[1], hi);
        chk("R3 other signatures", b ? (d[1] + d[3]) : (d[0] + d[2]), 0);
        chk("R3 scl low at end", int'(scl_dl), 1);
        chk("R3 sda holds bit", int'(sda_dl), int'(!b));
    endtask

    task automatic t_read(input bit v, input int hi, input int lo);
        mid_mode = 1;
        mid_val = v;
        mid_idx = hi / 2;
        run_op(4, 1'b0, 1'b0);
        mid_mode = 0;
        chk("R4 low ticks sda released", d[2], lo);
        chk("R4 high ticks sda released", d[0], hi);
        chk("R4 sda never pulled", d[1] + d[3], 0);
        chk("R4 sampled bit", int'(rx_bit), int'(v));
    endtask

    task automatic t_rstart(input int lo, input int rs, input int sh);
        run_op(1, 1'b0, 1'b0);
        chk("R5 low released ticks", d[2], lo);
        chk("R5 setup ticks", d[0], (rs == 0) ? 1 : rs);
        chk("R5 hold ticks", d[1], (sh == 0) ? 1 : sh);
        chk("R5 scl low at end", int'(scl_dl), 1);
        chk("R5 sda low at end", int'(sda_dl), 1);
    endtask

    task automatic t_stop(input int lo, input int ps);
        run_op(2, 1'b0, 1'b0);
        chk("R6 low ticks sda low", d[3], lo);
        chk("R6 setup ticks", d[1], (ps == 0) ? 1 : ps);
        chk("R6 scl released", int'(scl_dl), 0);
        chk("R6 sda released", int'(sda_dl), 0);
        if (ps == 0) chk("R8 zero stop setup one tick", d[1], 1);
        step();
        step();
        chk("R6 stays idle", int'(busy), 0);
    endtask

    // A stray STOP during a send must not alter the send.
    task automatic t_busy_ignore(input int hi, input int lo);
        run_op(3, 1'b1, 1'b1);
        chk("R9 low ticks unchanged", d[2], lo);
        chk("R9 high ticks unchanged", d[0], hi);
        chk("R9 no stop phase", d[1] + d[3], 0);
        chk("R9 still parked scl low", int'(scl_dl), 1);
        step();
        chk("R10 done one cycle", int'(done), 0);
        chk("R9 no pending op", int'(busy), 0);
    endtask

    // Zero high count halts the send until restored.
    task automatic t_halt(input int hi);
        scl_high = '0;
        req_valid = 1'b1;
        req_op = 3'd3;
        req_bit = 1'b0;
        step();
        req_valid = 1'b0;
        got_done = 0;
        for (int n = 0; n < 60; n++) begin
            step();
            if (done) got_done = 1;
        end
        chk("R7 no done while halted", int'(got_done), 0);
        chk("R7 busy while halted", int'(busy), 1);
        chk("R7 scl held low", int'(scl_dl), 1);
        scl_high = CW'(hi);
        got_done = 0;
        for (int n = 0; n < 5000 && !got_done; n++) begin
            if (done) got_done = 1;
            else step();
        end
        chk("R7 resumes to done", int'(got_done), 1);
        chk("R7 scl low at end", int'(scl_dl), 1);
    endtask

    initial begin
        set_cfg(6, 4, 'h0a, 'h0a, 5);
        repeat (4) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();

        t_start('h0a);
        t_write(1'b1, 6, 4);
        t_write(1'b0, 6, 4);
        t_read(1'b1, 6, 4);
        t_read(1'b0, 6, 4);
        t_rstart(4, 'h0a, 'h0a);
        t_busy_ignore(6, 4);
        t_halt(6);
        t_stop(4, 5);

        set_cfg(3, 2, 'h47, 'h50, 0);
        t_start('h47);
        t_write(1'b0, 3, 2);
        t_read(1'b1, 3, 2);
        t_rstart(2, 'h50, 'h47);
        t_stop(2, 0);

        set_cfg(1, 1, 0, 0, 2);
        t_start(0);
        t_read(1'b0, 1, 1);
        t_rstart(1, 0, 0);
        t_stop(1, 2);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule